// File: doc/BRIEF.md
# Command-Paced In-Memory Compute Sequencer

This block is the control unit of one processing lane that sits beside a DRAM bank. It holds a short program in a local instruction store and steps through it one instruction at a time. It has no free-running execution of its own. An instruction runs only when the memory controller issues a column command (read or write) while compute mode is on. For each instruction it runs, the block drives the opcode, its group, and the operand selects and register indices that the arithmetic datapath needs.

The program is loaded over a valid/ready write port. The port is ready only while compute mode is off. A word is stored in the cycle where valid and ready are both high. There is no other back-pressure and no queueing.

Each instruction states which column command it needs. An instruction whose destination is the bank needs a write. One that reads a bank operand needs a read. Every other instruction accepts either kind. When the command does not match, the block flags an error for one cycle and stays on the same instruction. Loops repeat a fixed number of times, and the exit instruction returns the lane to its starting state.

Top module: `imc_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc_o` is 0 and `ex_valid`, `cmd_err` and `ex_exit` are low.
- R2: `ld_ready` is high exactly when `pim_mode` is low. A word is written to entry `ld_addr` only when `ld_valid` and `ld_ready` are both high. A load presented while `pim_mode` is high leaves the store unchanged.
- R3: A column command (`col_cmd` high while `pim_mode` is high) that matches its instruction gives exactly one `ex_valid` pulse in the next cycle. With no command, or with `pim_mode` low, `ex_valid` stays low and `pc_o` does not change.
- R4: Opcode bits [31:28] are decoded as NOP=0, JUMP=1, EXIT=2, MOV=4, FILL=5, ADD=8, MUL=9, MAC=10 and MAD=11. `ex_group` is 0 for control (NOP, JUMP, EXIT), 1 for data movement (MOV, FILL) and 2 for arithmetic.
- R5: Operand select codes are 0 register file, 1 bank, 2 scalar file and 3 none. Destination is bits [27:26], sources 0/1/2 are bits [25:24]/[23:22]/[21:20], and indices are [17:15] for the destination, [14:12] for source 0 and [11:9] for source 1. Bit 19 is the clamp flag and applies to data movement only. Bit 18 is the aligned-mode flag and applies to non-control instructions. Data movement uses one source, ADD/MUL/MAC use two and MAD uses three. Unused selects read 3 and unused indices and flags read 0. Control instructions report every select as 3.
- R6: A destination of bank requires a write command. Otherwise, any used source of bank requires a read command. Otherwise, either command is accepted.
- R7: On a command of the wrong kind, `cmd_err` pulses in the next cycle, `ex_valid` stays low and `pc_o` keeps its value.
- R8: Each executed instruction other than a taken JUMP or an EXIT advances `pc_o` by one, wrapping from the last entry to 0.
- R9: JUMP carries a backward offset in bits [15:11] and a repeat count N in bits [10:0]. It branches to `pc - offset` on its first N executions and falls through on execution N+1, which re-arms it. N=0 always falls through.
- R10: EXIT sets `pc_o` to 0, clears the loop state and pulses `ex_exit` together with `ex_valid`.
- R11: Opcodes 3, 6, 7 and 12–15 execute as NOP: `ex_op` reads 0, the group is control, and either command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pim_mode | input | 1 | Compute mode active |
| col_cmd | input | 1 | Column command strobe |
| col_is_wr | input | 1 | Command kind: 1 write, 0 read |
| ld_valid | input | 1 | Program word offered |
| ld_ready | output | 1 | Store accepts program words |
| ld_addr | input | AW | Store entry to write |
| ld_data | input | 32 | Instruction word |
| pc_o | output | AW | Current program counter |
| ex_valid | output | 1 | One instruction executed |
| ex_op | output | 4 | Executed opcode |
| ex_group | output | 2 | Instruction group |
| ex_dst | output | 2 | Destination select |
| ex_src0 | output | 2 | Source 0 select |
| ex_src1 | output | 2 | Source 1 select |
| ex_src2 | output | 2 | Source 2 select |
| ex_dst_idx | output | 3 | Destination index |
| ex_src0_idx | output | 3 | Source 0 index |
| ex_src1_idx | output | 3 | Source 1 index |
| ex_relu | output | 1 | Clamp negatives on move |
| ex_aam | output | 1 | Aligned addressing flag |
| ex_exit | output | 1 | EXIT executed |
| cmd_err | output | 1 | Command kind mismatch |

## Verification
The bench builds the block with its default depth of 32 entries, so AW is 5. At that size a run walks the program counter through the wrap from entry 31 to 0. It also places a backward JUMP whose offset reaches several entries back. Directed commands of the wrong kind, loads offered while compute mode is on, a reloaded program and illegal opcodes are mixed with a long stretch of patterned commands. This drives loop re-arming, EXIT in the middle of a loop and stalls on mismatches in many different orders.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 4;
  localparam int IDX_W   = 3;
  localparam int JOFF_W  = 5;
  localparam int JCNT_W  = 11;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'd0,
    OP_JUMP  = 4'd1,
    OP_EXIT  = 4'd2,
    OP_MOV   = 4'd4,
    OP_FILL  = 4'd5,
    OP_ADD   = 4'd8,
    OP_MUL   = 4'd9,
    OP_MAC   = 4'd10,
    OP_MAD   = 4'd11
  } opc_e;

  typedef enum logic [1:0] {
    GRP_CTRL  = 2'd0,
    GRP_DATA  = 2'd1,
    GRP_ARITH = 2'd2
  } grp_e;

  typedef enum logic [1:0] {
    SEL_GRF  = 2'd0,
    SEL_BANK = 2'd1,
    SEL_SRF  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    opc_e              op;
    grp_e              grp;
    sel_e              dst;
    sel_e              src0;
    sel_e              src1;
    sel_e              src2;
    logic [IDX_W-1:0]  dst_idx;
    logic [IDX_W-1:0]  src0_idx;
    logic [IDX_W-1:0]  src1_idx;
    logic              relu;
    logic              aam;
    logic              is_jump;
    logic              is_exit;
    logic              need_wr;
    logic              need_rd;
    logic [JOFF_W-1:0] j_off;
    logic [JCNT_W-1:0] j_cnt;
  } dec_t;
endpackage

// File: rtl/imc_ibuf.sv
module imc_ibuf #(
  parameter int DEPTH = 32,
  parameter int IW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [IW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [IW-1:0] rd_data
);
  logic [IW-1:0] store [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(e))) store[e] <= wr_data;
    end
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/imc_decode.sv
module imc_decode
  import imc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [1:0] n_src;
  sel_e       slot [3];

  assign slot[0] = sel_e'(instr[25:24]);
  assign slot[1] = sel_e'(instr[23:22]);
  assign slot[2] = sel_e'(instr[21:20]);

  always_comb begin
    dec       = '0;
    dec.op    = OP_NOP;
    dec.grp   = GRP_CTRL;
    dec.dst   = SEL_NONE;
    dec.src0  = SEL_NONE;
    dec.src1  = SEL_NONE;
    dec.src2  = SEL_NONE;
    n_src     = 2'd0;
    case (instr[31:28])
      4'd1:  dec.op = OP_JUMP;
      4'd2:  dec.op = OP_EXIT;
      4'd4:  begin dec.op = OP_MOV;  dec.grp = GRP_DATA;  n_src = 2'd1; end
      4'd5:  begin dec.op = OP_FILL; dec.grp = GRP_DATA;  n_src = 2'd1; end
      4'd8:  begin dec.op = OP_ADD;  dec.grp = GRP_ARITH; n_src = 2'd2; end
      4'd9:  begin dec.op = OP_MUL;  dec.grp = GRP_ARITH; n_src = 2'd2; end
      4'd10: begin dec.op = OP_MAC;  dec.grp = GRP_ARITH; n_src = 2'd2; end
      4'd11: begin dec.op = OP_MAD;  dec.grp = GRP_ARITH; n_src = 2'd3; end
      default: dec.op = OP_NOP;
    endcase

    if (dec.grp != GRP_CTRL) begin
      dec.dst     = sel_e'(instr[27:26]);
      dec.dst_idx = instr[17:15];
      dec.aam     = instr[18];
    end
    dec.relu = (dec.grp == GRP_DATA) && instr[19];

    if (n_src >= 2'd1) begin
      dec.src0     = slot[0];
      dec.src0_idx = instr[14:12];
    end
    if (n_src >= 2'd2) begin
      dec.src1     = slot[1];
      dec.src1_idx = instr[11:9];
    end
    if (n_src == 2'd3) dec.src2 = slot[2];

    dec.need_wr = (dec.dst == SEL_BANK);
    dec.need_rd = (dec.src0 == SEL_BANK) || (dec.src1 == SEL_BANK) ||
                  (dec.src2 == SEL_BANK);

    dec.is_jump = (dec.op == OP_JUMP);
    dec.is_exit = (dec.op == OP_EXIT);
    if (dec.is_jump) begin
      dec.j_off = instr[15:11];
      dec.j_cnt = instr[10:0];
    end
  end
endmodule

// File: rtl/imc_ctrl.sv
module imc_ctrl
  import imc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             cmd,
  input  logic             cmd_wr,
  input  dec_t             dec,
  output logic [AW-1:0]    pc,
  output logic             ex_valid,
  output logic             ex_err,
  output logic             ex_exit,
  output opc_e             ex_op,
  output grp_e             ex_grp,
  output sel_e             ex_dst,
  output sel_e             ex_src0,
  output sel_e             ex_src1,
  output sel_e             ex_src2,
  output logic [IDX_W-1:0] ex_dst_idx,
  output logic [IDX_W-1:0] ex_src0_idx,
  output logic [IDX_W-1:0] ex_src1_idx,
  output logic             ex_relu,
  output logic             ex_aam
);
  logic              fire, bad, go;
  logic              loop_act, act_nxt;
  logic [JCNT_W-1:0] loop_cnt, cnt_nxt;
  logic [AW-1:0]     pc_nxt, target;

  assign fire   = mode && cmd;
  assign bad    = fire && ((dec.need_wr && !cmd_wr) ||
                           (!dec.need_wr && dec.need_rd && cmd_wr));
  assign go     = fire && !bad;
  assign target = pc - AW'(dec.j_off);

  always_comb begin
    pc_nxt  = pc + 1'b1;
    act_nxt = loop_act;
    cnt_nxt = loop_cnt;
    if (dec.is_exit) begin
      pc_nxt  = '0;
      act_nxt = 1'b0;
      cnt_nxt = '0;
    end else if (dec.is_jump) begin
      if (loop_act) begin
        if (loop_cnt == '0) begin
          act_nxt = 1'b0;
        end else begin
          cnt_nxt = loop_cnt - 1'b1;
          pc_nxt  = target;
        end
      end else if (dec.j_cnt != '0) begin
        act_nxt = 1'b1;
        cnt_nxt = dec.j_cnt - 1'b1;
        pc_nxt  = target;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc          <= '0;
      loop_act    <= 1'b0;
      loop_cnt    <= '0;
      ex_valid    <= 1'b0;
      ex_err      <= 1'b0;
      ex_exit     <= 1'b0;
      ex_op       <= OP_NOP;
      ex_grp      <= GRP_CTRL;
      ex_dst      <= SEL_NONE;
      ex_src0     <= SEL_NONE;
      ex_src1     <= SEL_NONE;
      ex_src2     <= SEL_NONE;
      ex_dst_idx  <= '0;
      ex_src0_idx <= '0;
      ex_src1_idx <= '0;
      ex_relu     <= 1'b0;
      ex_aam      <= 1'b0;
    end else begin
      ex_valid <= go;
      ex_err   <= bad;
      ex_exit  <= go && dec.is_exit;
      if (go) begin
        pc          <= pc_nxt;
        loop_act    <= act_nxt;
        loop_cnt    <= cnt_nxt;
        ex_op       <= dec.op;
        ex_grp      <= dec.grp;
        ex_dst      <= dec.dst;
        ex_src0     <= dec.src0;
        ex_src1     <= dec.src1;
        ex_src2     <= dec.src2;
        ex_dst_idx  <= dec.dst_idx;
        ex_src0_idx <= dec.src0_idx;
        ex_src1_idx <= dec.src1_idx;
        ex_relu     <= dec.relu;
        ex_aam      <= dec.aam;
      end
    end
  end
endmodule

// File: rtl/imc_sequencer.sv
module imc_sequencer
  import imc_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pim_mode,
  input  logic               col_cmd,
  input  logic               col_is_wr,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [AW-1:0]      ld_addr,
  input  logic [INSTR_W-1:0] ld_data,
  output logic [AW-1:0]      pc_o,
  output logic               ex_valid,
  output logic [OPC_W-1:0]   ex_op,
  output logic [1:0]         ex_group,
  output logic [1:0]         ex_dst,
  output logic [1:0]         ex_src0,
  output logic [1:0]         ex_src1,
  output logic [1:0]         ex_src2,
  output logic [IDX_W-1:0]   ex_dst_idx,
  output logic [IDX_W-1:0]   ex_src0_idx,
  output logic [IDX_W-1:0]   ex_src1_idx,
  output logic               ex_relu,
  output logic               ex_aam,
  output logic               ex_exit,
  output logic               cmd_err
);
  logic [INSTR_W-1:0] cur_instr;
  dec_t               cur_dec;
  opc_e               op_q;
  grp_e               grp_q;
  sel_e               dst_q, s0_q, s1_q, s2_q;

  assign ld_ready = !pim_mode;

  imc_ibuf #(.DEPTH(DEPTH), .IW(INSTR_W)) u_ibuf (
    .clk     (clk),
    .wr_en   (ld_valid && ld_ready),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (pc_o),
    .rd_data (cur_instr)
  );

  imc_decode u_dec (
    .instr (cur_instr),
    .dec   (cur_dec)
  );

  imc_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (pim_mode),
    .cmd         (col_cmd),
    .cmd_wr      (col_is_wr),
    .dec         (cur_dec),
    .pc          (pc_o),
    .ex_valid    (ex_valid),
    .ex_err      (cmd_err),
    .ex_exit     (ex_exit),
    .ex_op       (op_q),
    .ex_grp      (grp_q),
    .ex_dst      (dst_q),
    .ex_src0     (s0_q),
    .ex_src1     (s1_q),
    .ex_src2     (s2_q),
    .ex_dst_idx  (ex_dst_idx),
    .ex_src0_idx (ex_src0_idx),
    .ex_src1_idx (ex_src1_idx),
    .ex_relu     (ex_relu),
    .ex_aam      (ex_aam)
  );

  assign ex_op    = op_q;
  assign ex_group = grp_q;
  assign ex_dst   = dst_q;
  assign ex_src0  = s0_q;
  assign ex_src1  = s1_q;
  assign ex_src2  = s2_q;
endmodule

// File: rtl/imc_sequencer_chk.sv
module imc_sequencer_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pim_mode,
  input logic          col_cmd,
  input logic          ld_ready,
  input logic [AW-1:0] pc_o,
  input logic          ex_valid,
  input logic [1:0]    ex_group,
  input logic [1:0]    ex_dst,
  input logic          ex_exit,
  input logic          cmd_err
);
  a_r2_no_load_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    pim_mode |-> !ld_ready);

  a_r3_exec_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> $past(pim_mode && col_cmd));

  a_r3_pc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pim_mode && col_cmd) |-> $stable(pc_o));

  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ex_valid && cmd_err));

  a_r7_err_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $stable(pc_o));

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_group != 2'd0) |-> (pc_o == AW'($past(pc_o) + 1'b1)));

  a_r10_exit_home: assert property (@(posedge clk) disable iff (!rst_n)
    ex_exit |-> (ex_valid && pc_o == '0));

  a_r5_ctrl_no_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_group == 2'd0) |-> (ex_dst == 2'd3));
endmodule

bind imc_sequencer imc_sequencer_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pim_mode (pim_mode),
  .col_cmd  (col_cmd),
  .ld_ready (ld_ready),
  .pc_o     (pc_o),
  .ex_valid (ex_valid),
  .ex_group (ex_group),
  .ex_dst   (ex_dst),
  .ex_exit  (ex_exit),
  .cmd_err  (cmd_err)
);

// File: tb/imc_sequencer_tb.sv
`timescale 1ns/100ps
module imc_sequencer_tb_top;
  localparam int DEPTH = 32;
  localparam int AW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pim_mode = 1'b0, col_cmd = 1'b0, col_is_wr = 1'b0, ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic          ld_ready, ex_valid, ex_relu, ex_aam, ex_exit, cmd_err;
  logic [AW-1:0] pc_o;
  logic [3:0]    ex_op;
  logic [1:0]    ex_group, ex_dst, ex_src0, ex_src1, ex_src2;
  logic [2:0]    ex_dst_idx, ex_src0_idx, ex_src1_idx;

  always #2.5 clk = ~clk;

  imc_sequencer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .pim_mode(pim_mode), .col_cmd(col_cmd),
    .col_is_wr(col_is_wr), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .ex_valid(ex_valid),
    .ex_op(ex_op), .ex_group(ex_group), .ex_dst(ex_dst), .ex_src0(ex_src0),
    .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_dst_idx(ex_dst_idx),
    .ex_src0_idx(ex_src0_idx), .ex_src1_idx(ex_src1_idx), .ex_relu(ex_relu),
    .ex_aam(ex_aam), .ex_exit(ex_exit), .cmd_err(cmd_err)
  );

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // reference state
  logic [31:0] mem [DEPTH];
  int  mpc = 0, mact = 0, mcnt = 0;
  bit  e_valid, e_err, e_exit;
  logic [24:0] e_f;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural decode from the requirement text
  task automatic bdec(input logic [31:0] w, output logic [24:0] f,
                      output bit nrd, output bit nwr, output bit isj, output bit ise);
    int op, grp, ns;
    int s [3];
    int d, di, i0, i1, rl, am;
    op = w[31:28];
    case (op)
      1, 2:        begin grp = 0; ns = 0; end
      4, 5:        begin grp = 1; ns = 1; end
      8, 9, 10:    begin grp = 2; ns = 2; end
      11:          begin grp = 2; ns = 3; end
      default:     begin grp = 0; ns = 0; op = 0; end
    endcase
    d  = (grp == 0) ? 3 : w[27:26];
    s[0] = (ns >= 1) ? w[25:24] : 3;
    s[1] = (ns >= 2) ? w[23:22] : 3;
    s[2] = (ns >= 3) ? w[21:20] : 3;
    di = (grp == 0) ? 0 : w[17:15];
    i0 = (ns >= 1) ? w[14:12] : 0;
    i1 = (ns >= 2) ? w[11:9] : 0;
    rl = (grp == 1) ? w[19] : 0;
    am = (grp == 0) ? 0 : w[18];
    f  = {op[3:0], grp[1:0], d[1:0], s[0][1:0], s[1][1:0], s[2][1:0],
          di[2:0], i0[2:0], i1[2:0], rl[0], am[0]};
    nwr = (d == 1);
    nrd = (s[0] == 1) || (s[1] == 1) || (s[2] == 1);
    isj = (op == 1);
    ise = (op == 2);
  endtask

  task automatic model();
    logic [24:0] f;
    bit nrd, nwr, isj, ise, bad;
    e_valid = 0; e_err = 0; e_exit = 0;
    if (ld_valid && !pim_mode) mem[ld_addr] = ld_data;
    if (pim_mode && col_cmd) begin
      bdec(mem[mpc], f, nrd, nwr, isj, ise);
      bad = (nwr && !col_is_wr) || (!nwr && nrd && col_is_wr);
      if (bad) e_err = 1;
      else begin
        e_valid = 1;
        e_f = f;
        if (ise) begin
          mpc = 0; mact = 0; mcnt = 0; e_exit = 1;
        end else if (isj) begin
          if (mact != 0) begin
            if (mcnt == 0) begin mact = 0; mpc = (mpc + 1) % DEPTH; end
            else begin mcnt--; mpc = (mpc - int'(mem[mpc][15:11]) + DEPTH) % DEPTH; end
          end else if (mem[mpc][10:0] != 0) begin
            mact = 1; mcnt = int'(mem[mpc][10:0]) - 1;
            mpc = (mpc - int'(mem[mpc][15:11]) + DEPTH) % DEPTH;
          end else mpc = (mpc + 1) % DEPTH;
        end else mpc = (mpc + 1) % DEPTH;
      end
    end
  endtask

  task automatic compare();
    logic [24:0] got;
    got = {ex_op, ex_group, ex_dst, ex_src0, ex_src1, ex_src2,
           ex_dst_idx, ex_src0_idx, ex_src1_idx, ex_relu, ex_aam};
    chk(pc_o == AW'(mpc), "R8 R9 R10 pc", int'(pc_o), mpc);
    chk(ex_valid == e_valid, "R3 exec pulse", int'(ex_valid), int'(e_valid));
    chk(cmd_err == e_err, "R6 R7 cmd kind", int'(cmd_err), int'(e_err));
    chk(ex_exit == e_exit, "R10 exit pulse", int'(ex_exit), int'(e_exit));
    chk(ld_ready == !pim_mode, "R2 load ready", int'(ld_ready), int'(!pim_mode));
    if (e_valid) chk(got == e_f, "R4 R5 R11 decode", int'(got), int'(e_f));
  endtask

  task automatic step(input bit m, input bit c, input bit w, input bit lv,
                      input int a, input logic [31:0] d);
    pim_mode = m; col_cmd = c; col_is_wr = w; ld_valid = lv;
    ld_addr = AW'(a); ld_data = d;
    model();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic step_auto();
    logic [24:0] f;
    bit nrd, nwr, isj, ise;
    bdec(mem[mpc], f, nrd, nwr, isj, ise);
    step(1, 1, nwr, 0, 0, '0);
  endtask

  function automatic logic [31:0] mk(input int op, input int d, input int s0,
      input int s1, input int s2, input int rl, input int am, input int di,
      input int i0, input int i1);
    logic [31:0] w;
    w = '0;
    w[31:28] = op[3:0]; w[27:26] = d[1:0]; w[25:24] = s0[1:0];
    w[23:22] = s1[1:0]; w[21:20] = s2[1:0]; w[19] = rl[0]; w[18] = am[0];
    w[17:15] = di[2:0]; w[14:12] = i0[2:0]; w[11:9] = i1[2:0];
    return w;
  endfunction

  function automatic logic [31:0] mkj(input int off, input int cnt);
    logic [31:0] w;
    w = '0; w[31:28] = 4'd1; w[15:11] = off[4:0]; w[10:0] = cnt[10:0];
    return w;
  endfunction

  logic [31:0] prog [9];
  logic [31:0] tmpl [6];

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    prog[0] = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);      // NOP
    prog[1] = mk(4, 0, 1, 0, 0, 1, 0, 5, 2, 0);      // MOV bank->grf, clamp
    prog[2] = mk(5, 1, 0, 0, 0, 1, 1, 3, 6, 0);      // FILL grf->bank
    prog[3] = mk(8, 0, 0, 2, 1, 0, 1, 7, 1, 4);      // ADD grf,srf
    prog[4] = mk(11, 0, 1, 2, 0, 0, 0, 2, 3, 5);     // MAD bank,srf,grf
    prog[5] = mkj(3, 2);                              // JUMP to 2, twice
    prog[6] = mk(7, 2, 1, 1, 1, 1, 1, 7, 7, 7);      // illegal -> NOP
    prog[7] = mk(9, 0, 2, 1, 3, 1, 1, 1, 2, 3);      // MUL
    prog[8] = mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);      // EXIT
    tmpl[0] = mk(10, 1, 0, 0, 0, 0, 1, 4, 1, 2);     // MAC -> bank (wr)
    tmpl[1] = mkj(2, 1);
    tmpl[2] = mk(13, 1, 1, 1, 1, 0, 0, 0, 0, 0);     // illegal
    tmpl[3] = mk(4, 2, 0, 0, 0, 1, 0, 6, 2, 0);      // MOV grf->srf
    tmpl[4] = mk(9, 0, 0, 1, 2, 0, 0, 3, 3, 3);      // MUL bank src1 (rd)
    tmpl[5] = mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);      // EXIT

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc_o == '0 && !ex_valid && !cmd_err && !ex_exit, "R1 reset", int'(pc_o), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(pc_o == '0 && !ex_valid && !cmd_err && !ex_exit, "R1 after reset", int'(pc_o), 0);
    chk(ld_ready == 1'b1, "R2 ready while idle", int'(ld_ready), 1);

    // R2: load whole store, then program
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, i, '0);
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, i, prog[i]);

    // R3: commands with mode off do nothing
    step(0, 1, 0, 0, 0, '0);
    step(0, 1, 1, 0, 0, '0);
    // R2: load attempt while mode on is ignored (entry 1 keeps MOV)
    step(1, 0, 0, 1, 1, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(1, 0, 0, 0, 0, '0);

    // R6 R7 directed: NOP on write, MOV on write (bad) then read,
    // FILL on read (bad) then write
    step(1, 1, 1, 0, 0, '0);
    step(1, 1, 1, 0, 0, '0);
    chk(cmd_err == 1'b1, "R7 MOV on write flagged", int'(cmd_err), 1);
    step(1, 1, 0, 0, 0, '0);
    step(1, 1, 0, 0, 0, '0);
    chk(cmd_err == 1'b1 && pc_o == AW'(2), "R6 FILL on read flagged", int'(pc_o), 2);
    step(1, 1, 1, 0, 0, '0);
    step(1, 1, 1, 0, 0, '0);   // ADD on write ok
    // R9 R11 R10: loop twice then run out to EXIT
    for (int i = 0; i < 20; i++) step_auto();

    // R8: replace EXIT with NOP so pc wraps past the last entry
    step(0, 0, 0, 1, 8, '0);
    for (int i = 0; i < 50; i++) step_auto();
    step(0, 0, 0, 1, 8, prog[8]);

    // patterned mix of commands, kinds, idle cycles and reloads
    for (int i = 0; i < 600; i++) begin
      bit m, c, w, lv;
      m  = (i % 37) < 31;
      c  = ((i * 7) % 5) != 0;
      w  = ((i * 13) % 7) < 3;
      lv = !m && ((i % 3) == 0);
      step(m, c, w, lv, (i * 5) % DEPTH, tmpl[(i / 3) % 6]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule